// File: doc/BRIEF.md
# Two-Bit Configurable Carry Slice

This block models the carry and arithmetic path of one logic slice. It holds two small lookup tables, one per bit, and around each table a fixed set of arithmetic gates: a multiplexer that either forwards the incoming carry or injects a locally chosen carry value, a sum XOR, and a two-input AND that forms a partial-product term. A selector at the slice's lower edge decides whether the chain starts from the carry arriving from the slice below or from a bypass input. The result is a slice that can be set up as an adder stage, a counter stage, a multiplier partial-product row or plain logic.

Slices are stacked by wiring one slice's `cout` to the next slice's `cin`. Truth tables are written through a small configuration port before use. The remaining configuration inputs are static and select the carry-generate source, the chain start point and the output form per bit. A per-bit register with clock enable can hold each bit's output, so a counter can feed its registered outputs back into its own lookup tables.

Top module: `carry_slice2`

## Requirements
- R1: When `cfg_we` is 1 at a rising edge, `cfg_tt` is stored in the table selected by `cfg_sel`. That table's output is then `cfg_tt[idx]`, where idx is `lut_in[k]` read as an unsigned number with input 0 as its LSB.
- R2: The slice's starting carry is `cin` when `cfg_init_byp` is 0 and `byp[0]` when it is 1.
- R3: A bit whose table output is 1 forwards its incoming carry to its carry output. A bit whose table output is 0 drives its carry output with its generate value.
- R4: The generate value of bit k is chosen by `cfg_gen[k]`: 0 selects `lut_in[k][0]`, 1 selects the AND term, 2 selects `byp[k]` and 3 selects `cfg_const[k]`.
- R5: The AND term of bit k is `lut_in[k][0] & lut_in[k][1]`.
- R6: `comb_out[k]` equals the table output XOR the bit's incoming carry when `cfg_use_sum[k]` is 1, and the bare table output when it is 0.
- R7: The carry output of bit 0 is the incoming carry of bit 1, and the carry output of the top bit drives `cout`.
- R8: At a rising edge with `ce` at 1, `reg_out` takes the value of `comb_out`. With `ce` at 0 it keeps its value.
- R9: A rising edge with `rst_n` at 0 clears `reg_out` and clears both truth tables to all zeros.
- R10: Slices chained through `cin`/`cout` make an N-bit adder (XOR tables, generate from input 0), a counter (pass-through tables on the registered outputs, generate constant 0, start carry from `byp[0]` as increment), and a multiplier row adding `a` gated by one multiplier bit to an accumulator (table `(in0&in1)^in2`, generate from the AND term).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table writes and output registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Truth-table write strobe |
| cfg_sel | input | SELW | Selects which bit's table is written |
| cfg_tt | input | 2**LUT_IN | Truth table to write |
| cfg_init_byp | input | 1 | Starting carry from `byp[0]` (1) or `cin` (0) |
| cfg_gen | input | NBITS x 2 | Per-bit generate source code |
| cfg_const | input | NBITS | Per-bit constant generate value |
| cfg_use_sum | input | NBITS | Per-bit output form: sum (1) or table (0) |
| ce | input | 1 | Clock enable of the output registers |
| lut_in | input | NBITS x LUT_IN | Table inputs per bit |
| byp | input | NBITS | Per-bit bypass inputs |
| cin | input | 1 | Carry from the slice below |
| comb_out | output | NBITS | Combinational bit outputs |
| reg_out | output | NBITS | Registered bit outputs |
| cout | output | 1 | Carry to the slice above |

## Verification
The bench uses the default two bits per slice and four-input tables. That lets a single instance be driven through every generate code, every start-carry choice and every table index. Four such slices are then chained into 8-bit words, which puts carries across slice boundaries within reach: a full ripple from 0xFF plus 1, counter wraparound from 255 to 0, and multiplier rows whose sum overflows into the final carry-out.

// File: rtl/cslice_pkg.sv
// Shared types for the two-bit carry slice.
package cslice_pkg;

    // Source of a bit's carry-generate value
    typedef enum logic [1:0] {
        GEN_LUTIN = 2'd0,   // table input 0
        GEN_AND   = 2'd1,   // partial-product AND term
        GEN_BYP   = 2'd2,   // bypass input of the bit
        GEN_CONST = 2'd3    // configured constant
    } gen_src_e;

    // Static per-bit configuration
    typedef struct packed {
        gen_src_e gsrc;
        logic     konst;
        logic     use_sum;
    } bit_cfg_t;

endpackage

// File: rtl/cslice_lut.sv
// Truth-table lookup for one bit.
// Holds 2**LUT_IN configuration bits written whole by a strobe and
// reads them combinationally at the index formed by the inputs.
// Assumes the table is written before its output is used.
module cslice_lut #(
    parameter  int LUT_IN = 4,
    localparam int DEPTH  = 1 << LUT_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DEPTH-1:0]  data,
    input  logic [LUT_IN-1:0] idx,
    output logic              y
);

    logic [DEPTH-1:0] tt;

    // Store or clear the truth table
    always_ff @(posedge clk) begin
        if (!rst_n)  tt <= '0;
        else if (we) tt <= data;
    end

    // Read the table at the input index
    assign y = tt[idx];

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> tt == $past(data));

endmodule

// File: rtl/cslice_bit.sv
// Arithmetic gates of one bit: generate selector, carry multiplexer,
// sum XOR, partial-product AND and output form selector.
// Purely combinational; clk and rst_n serve only the local checks.
module cslice_bit
    import cslice_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lut_y,
    input  logic     a0,
    input  logic     a1,
    input  logic     byp,
    input  bit_cfg_t cfg,
    input  logic     cy_in,
    output logic     out,
    output logic     cy_out
);

    logic and_t;
    logic gen;
    logic sum;

    // Partial-product term from the two lowest table inputs
    assign and_t = a0 & a1;

    // Pick the generate value
    always_comb begin
        unique case (cfg.gsrc)
            GEN_LUTIN: gen = a0;
            GEN_AND:   gen = and_t;
            GEN_BYP:   gen = byp;
            GEN_CONST: gen = cfg.konst;
            default:   gen = 1'b0;
        endcase
    end

    // Carry multiplexer: table output selects propagate or generate
    assign cy_out = lut_y ? cy_in : gen;

    // Sum and output form
    assign sum = lut_y ^ cy_in;
    assign out = cfg.use_sum ? sum : lut_y;

    p_prop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lut_y |-> cy_out == cy_in);

    p_byp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lut_y && cfg.gsrc == GEN_BYP) |-> cy_out == byp);

    p_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lut_y && cfg.gsrc == GEN_AND) |-> cy_out == (a0 & a1));

endmodule

// File: rtl/cslice_reg.sv
// Output registers with clock enable and synchronous active-low reset.
module cslice_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture when enabled, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ce) q <= d;
    end

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> q == $past(d));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(q));

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> q == '0);

endmodule

// File: rtl/carry_slice2.sv
// Two-bit configurable carry slice.
// Each bit has a lookup table and its arithmetic gates. Bits ripple
// from bit 0 upward; the start carry comes from cin or byp[0].
// Assumes the static configuration is held steady while in use.
module carry_slice2
    import cslice_pkg::*;
#(
    parameter  int NBITS  = 2,
    parameter  int LUT_IN = 4,
    localparam int DEPTH  = 1 << LUT_IN,
    localparam int SELW   = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [SELW-1:0]              cfg_sel,
    input  logic [DEPTH-1:0]             cfg_tt,
    input  logic                         cfg_init_byp,
    input  logic [NBITS-1:0][1:0]        cfg_gen,
    input  logic [NBITS-1:0]             cfg_const,
    input  logic [NBITS-1:0]             cfg_use_sum,
    input  logic                         ce,
    input  logic [NBITS-1:0][LUT_IN-1:0] lut_in,
    input  logic [NBITS-1:0]             byp,
    input  logic                         cin,
    output logic [NBITS-1:0]             comb_out,
    output logic [NBITS-1:0]             reg_out,
    output logic                         cout
);

    logic [NBITS:0]   cy;
    logic [NBITS-1:0] prop;

    // Start point of the chain
    assign cy[0] = cfg_init_byp ? byp[0] : cin;

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        logic     sel_hit;
        logic     lut_y;
        bit_cfg_t bc;

        // Write strobe for this bit's table
        assign sel_hit = cfg_we && (cfg_sel == SELW'(i));
        assign bc      = '{gsrc: gen_src_e'(cfg_gen[i]),
                           konst: cfg_const[i],
                           use_sum: cfg_use_sum[i]};

        cslice_lut #(.LUT_IN(LUT_IN)) u_lut (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (sel_hit),
            .data (cfg_tt),
            .idx  (lut_in[i]),
            .y    (lut_y)
        );

        cslice_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .lut_y (lut_y),
            .a0    (lut_in[i][0]),
            .a1    (lut_in[i][1]),
            .byp   (byp[i]),
            .cfg   (bc),
            .cy_in (cy[i]),
            .out   (comb_out[i]),
            .cy_out(cy[i+1])
        );

        assign prop[i] = lut_y;
    end

    cslice_reg #(.W(NBITS)) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .ce   (ce),
        .d    (comb_out),
        .q    (reg_out)
    );

    // Carry leaves from the top bit
    assign cout = cy[NBITS];

    p_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&prop && !cfg_init_byp) |-> cout == cin);

    p_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&prop && cfg_init_byp) |-> cout == byp[0]);

endmodule

// File: tb/sim_carry_slice2.sv
// Directed bench: one slice alone, then four-slice chains.
module sim_carry_slice2;
    localparam int CLK_P = 10;
    localparam int NS    = 4;
    localparam int W     = 2 * NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_tt  = '0;
    logic we0 = 0, we_add = 0, we_cnt = 0, we_mul = 0;

    // Single slice
    logic            u_init = 0;
    logic [1:0][1:0] u_gen = '0;
    logic [1:0]      u_const = '0, u_sum = '0, u_byp = '0;
    logic            u_ce = 0, u_cin = 0;
    logic [1:0][3:0] u_in = '0;
    logic [1:0]      u_comb, u_reg;
    logic            u_cout;

    carry_slice2 u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(we0), .cfg_sel(cfg_sel),
        .cfg_tt(cfg_tt), .cfg_init_byp(u_init), .cfg_gen(u_gen),
        .cfg_const(u_const), .cfg_use_sum(u_sum), .ce(u_ce),
        .lut_in(u_in), .byp(u_byp), .cin(u_cin),
        .comb_out(u_comb), .reg_out(u_reg), .cout(u_cout)
    );

    // Adder chain
    logic [W-1:0] add_a = '0, add_b = '0, add_sum;
    logic         add_c0 = 0;
    logic [NS:0]  add_c;
    assign add_c[0] = 1'b0;

    // Counter chain
    logic [W-1:0] cnt_q;
    logic         cnt_ce = 0, cnt_inc = 0;
    logic [NS:0]  cnt_c;
    assign cnt_c[0] = 1'b0;

    // Multiplier row chain
    logic [W-1:0] mul_a = '0, mul_acc = '0, mul_sum;
    logic         mul_b = 0;
    logic [NS:0]  mul_c;
    assign mul_c[0] = 1'b0;

    for (genvar s = 0; s < NS; s++) begin : g_chain
        logic [1:0][3:0] li_add, li_cnt, li_mul;
        logic [1:0]      ro_add, ro_mul, co_cnt;
        assign li_add[0] = {2'b00, add_b[2*s],   add_a[2*s]};
        assign li_add[1] = {2'b00, add_b[2*s+1], add_a[2*s+1]};
        assign li_cnt[0] = {3'b000, cnt_q[2*s]};
        assign li_cnt[1] = {3'b000, cnt_q[2*s+1]};
        assign li_mul[0] = {1'b0, mul_acc[2*s],   mul_b, mul_a[2*s]};
        assign li_mul[1] = {1'b0, mul_acc[2*s+1], mul_b, mul_a[2*s+1]};

        carry_slice2 u_add (
            .clk(clk), .rst_n(rst_n), .cfg_we(we_add), .cfg_sel(cfg_sel),
            .cfg_tt(cfg_tt), .cfg_init_byp(s == 0), .cfg_gen(4'h0),
            .cfg_const(2'b00), .cfg_use_sum(2'b11), .ce(1'b0),
            .lut_in(li_add), .byp((s == 0) ? {1'b0, add_c0} : 2'b00),
            .cin(add_c[s]), .comb_out(add_sum[2*s+:2]), .reg_out(ro_add),
            .cout(add_c[s+1])
        );

        carry_slice2 u_cnt (
            .clk(clk), .rst_n(rst_n), .cfg_we(we_cnt), .cfg_sel(cfg_sel),
            .cfg_tt(cfg_tt), .cfg_init_byp(s == 0), .cfg_gen(4'hF),
            .cfg_const(2'b00), .cfg_use_sum(2'b11), .ce(cnt_ce),
            .lut_in(li_cnt), .byp((s == 0) ? {1'b0, cnt_inc} : 2'b00),
            .cin(cnt_c[s]), .comb_out(co_cnt), .reg_out(cnt_q[2*s+:2]),
            .cout(cnt_c[s+1])
        );

        carry_slice2 u_mul (
            .clk(clk), .rst_n(rst_n), .cfg_we(we_mul), .cfg_sel(cfg_sel),
            .cfg_tt(cfg_tt), .cfg_init_byp(1'b0), .cfg_gen(4'h5),
            .cfg_const(2'b00), .cfg_use_sum(2'b11), .ce(1'b0),
            .lut_in(li_mul), .byp(2'b00),
            .cin(mul_c[s]), .comb_out(mul_sum[2*s+:2]), .reg_out(ro_mul),
            .cout(mul_c[s+1])
        );
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // kind 0: in0^in1, 1: in0, 2: (in0&in1)^in2
    function automatic logic [15:0] mk_tt(input int kind);
        logic [15:0] t;
        for (int i = 0; i < 16; i++) begin
            case (kind)
                0:       t[i] = i[0] ^ i[1];
                1:       t[i] = i[0];
                default: t[i] = (i[0] & i[1]) ^ i[2];
            endcase
        end
        return t;
    endfunction

    task automatic load(input int grp, input logic sel, input logic [15:0] tt);
        @(negedge clk);
        cfg_sel = sel;
        cfg_tt  = tt;
        case (grp)
            0:       we0 = 1;
            1:       we_add = 1;
            2:       we_cnt = 1;
            default: we_mul = 1;
        endcase
        @(negedge clk);
        we0 = 0; we_add = 0; we_cnt = 0; we_mul = 0;
    endtask

    task automatic t_reset();
        check("R9 reset reg_out", u_reg, 2'b00);
        check("R9 reset counter", cnt_q, 8'h00);
    endtask

    task automatic t_lut();
        logic [15:0] t0 = 16'hC3A5, t1 = 16'h5F12;
        load(0, 1'b0, t0);
        load(0, 1'b1, t1);
        u_sum = 2'b00;
        for (int i = 0; i < 16; i++) begin
            u_in[0] = 4'(i);
            u_in[1] = 4'(i) ^ 4'h5;
            #1;
            check("R1 table bit0", u_comb[0], t0[i]);
            check("R1 table bit1", u_comb[1], t1[4'(i) ^ 4'h5]);
        end
    endtask

    task automatic t_carry();
        logic exp;
        // both tables zero: cout is bit1's generate
        load(0, 1'b0, 16'h0000);
        load(0, 1'b1, 16'h0000);
        for (int src = 0; src < 4; src++) begin
            for (int v = 0; v < 16; v++) begin
                u_gen[1]   = 2'(src);
                u_in[1]    = {2'b00, v[1], v[0]};
                u_byp[1]   = v[2];
                u_const[1] = v[3];
                #1;
                case (src)
                    0:       exp = v[0];
                    1:       exp = v[0] & v[1];
                    2:       exp = v[2];
                    default: exp = v[3];
                endcase
                check(src == 1 ? "R5 and term" : "R4 generate select", u_cout, exp);
            end
        end
        // bit1 propagates: bit0's generate reaches cout
        load(0, 1'b1, 16'hFFFF);
        u_gen[0] = 2'd3;
        for (int k = 0; k < 2; k++) begin
            u_const[0] = k[0];
            #1;
            check("R7 bit0 carry into bit1", u_cout, k[0]);
            check("R3 generate on zero table", u_cout, k[0]);
        end
        // both propagate: start carry selection and sums
        load(0, 1'b0, 16'hFFFF);
        u_sum = 2'b11;
        for (int v = 0; v < 8; v++) begin
            u_init = v[0]; u_cin = v[1]; u_byp[0] = v[2];
            #1;
            exp = v[0] ? v[2] : v[1];
            check("R2 start carry", u_cout, exp);
            check("R6 sum output", u_comb, {~exp, ~exp});
        end
        u_init = 0; u_cin = 0; u_byp = '0;
    endtask

    task automatic t_reg();
        load(0, 1'b0, 16'hAAAA);
        load(0, 1'b1, 16'hAAAA);
        u_sum = 2'b00;
        u_in[0] = 4'h1; u_in[1] = 4'h0;
        u_ce = 1;
        @(negedge clk);
        check("R8 capture", u_reg, 2'b01);
        u_in[0] = 4'h0; u_in[1] = 4'h1;
        @(negedge clk);
        check("R8 capture", u_reg, 2'b10);
        u_ce = 0;
        u_in[0] = 4'h1; u_in[1] = 4'h0;
        repeat (3) @(negedge clk);
        check("R8 hold", u_reg, 2'b10);
        check("R8 comb differs", u_comb, 2'b01);
    endtask

    task automatic t_adder();
        logic [8:0] exp;
        load(1, 1'b0, mk_tt(0));
        load(1, 1'b1, mk_tt(0));
        for (int n = 0; n < 28; n++) begin
            case (n)
                0:       begin add_a = 8'hFF; add_b = 8'h01; add_c0 = 0; end
                1:       begin add_a = 8'hFF; add_b = 8'hFF; add_c0 = 1; end
                2:       begin add_a = 8'h00; add_b = 8'h00; add_c0 = 1; end
                3:       begin add_a = 8'h55; add_b = 8'hAA; add_c0 = 1; end
                default: begin add_a = 8'($urandom); add_b = 8'($urandom); add_c0 = 1'($urandom); end
            endcase
            #1;
            exp = 9'(add_a) + 9'(add_b) + 9'(add_c0);
            check("R10 adder", {add_c[NS], add_sum}, exp);
        end
    endtask

    task automatic t_counter();
        load(2, 1'b0, mk_tt(1));
        load(2, 1'b1, mk_tt(1));
        cnt_ce = 1; cnt_inc = 1;
        repeat (255) @(negedge clk);
        check("R10 counter at 255", cnt_q, 8'hFF);
        @(negedge clk);
        check("R10 counter wrap", cnt_q, 8'h00);
        repeat (44) @(negedge clk);
        check("R10 counter 44", cnt_q, 8'd44);
        cnt_ce = 0;
        repeat (5) @(negedge clk);
        check("R8 counter ce hold", cnt_q, 8'd44);
        cnt_ce = 1; cnt_inc = 0;
        repeat (5) @(negedge clk);
        check("R10 counter no increment", cnt_q, 8'd44);
        cnt_inc = 1;
        repeat (3) @(negedge clk);
        check("R10 counter resumes", cnt_q, 8'd47);
    endtask

    task automatic t_mult();
        logic [8:0] exp;
        load(3, 1'b0, mk_tt(2));
        load(3, 1'b1, mk_tt(2));
        for (int n = 0; n < 24; n++) begin
            case (n)
                0:       begin mul_a = 8'hFF; mul_acc = 8'hFF; mul_b = 1; end
                1:       begin mul_a = 8'hFF; mul_acc = 8'hFF; mul_b = 0; end
                default: begin mul_a = 8'($urandom); mul_acc = 8'($urandom); mul_b = 1'($urandom); end
            endcase
            #1;
            exp = 9'(mul_acc) + (mul_b ? 9'(mul_a) : 9'd0);
            check("R10 multiplier row", {mul_c[NS], mul_sum}, exp);
        end
    endtask

    task automatic t_reset_mid();
        u_ce = 1;
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        cnt_ce = 0; u_ce = 0;
        check("R9 counter cleared", cnt_q, 8'h00);
        check("R9 reg cleared", u_reg, 2'b00);
        u_sum = 2'b00;
        u_in[0] = 4'h1; u_in[1] = 4'h1;
        #1;
        check("R9 tables cleared", u_comb, 2'b00);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_lut();
        t_carry();
        t_reg();
        t_adder();
        t_counter();
        t_mult();
        t_reset_mid();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule